// File: doc/BRIEF.md
# SPI Memory-Window Access Master

This block is an SPI master that moves one chunk of data into or out of a remote device's 32-bit memory space. One frame is started per request. A command byte and a 32-bit target address come first, then the data phase. A read inserts four dummy bytes before the data is clocked back. A write appends one dummy byte after its data. The caller decides how to split a transfer into chunks and what command byte to use. The block only carries out the single frame it is given.

The remote memory is little-endian, but every byte goes on the wire most significant bit first. Data is therefore exchanged in words of 2, 4 or 8 bytes, and the byte order is reversed inside each word. Write data is fetched from a local byte buffer through an index/data port. Read data is returned through a write strobe with an index. When the source holds fewer bytes than the frame carries, the missing positions are sent as zero. SCLK is the system clock divided by a parameter.

Top module: `spi_window_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy is 0, done is 0 and rd_we is 0.
- R2: The first five frame bytes are the command byte, then address bits 31:24, 23:16, 15:8 and 7:0, each sent MSB first.
- R3: A read frame is 9 + len bytes long: header, four zero dummy bytes, then len data bytes during which mosi is 0.
- R4: A write frame is 6 + len bytes long: header, len data bytes, then one zero dummy byte.
- R5: word_sel selects the word size: 0 is 2 bytes, 1 is 4 bytes and 2 is 8 bytes. Write data byte p of the data phase carries local byte p XOR (size-1).
- R6: During a write, a data byte whose local index is at or above src_len is sent as 0.
- R7: Read data byte p is sampled from miso on rising sclk edges and delivered through rd_we with rd_idx equal to p XOR (size-1).
- R8: The bus uses SPI mode 0. sclk idles low, and mosi changes only while sclk is low.
- R9: cs_n stays low from the first command bit to the last frame bit. It then stays high for 2*CLK_DIV clocks before done, and sclk is low whenever cs_n is high.
- R10: busy is high from an accepted start until done. done is a one-cycle pulse as busy falls. A start while busy has no effect on the frame.
- R11: A data phase of 240 bytes, the largest allowed, is framed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame when idle |
| rd_mode | input | 1 | 1 = read frame, 0 = write frame |
| word_sel | input | 2 | Word size: 0 = 2, 1 = 4, 2 = 8 bytes |
| opcode | input | 8 | Command byte |
| addr | input | 32 | Remote start address |
| len | input | LW | Data phase length in bytes |
| src_len | input | LW | Valid source bytes for a write |
| wr_idx | output | LW | Local buffer index of the write byte needed |
| wr_byte | input | 8 | Local buffer byte at wr_idx |
| rd_we | output | 1 | Read byte strobe |
| rd_idx | output | LW | Local buffer index for rd_byte |
| rd_byte | output | 8 | Received byte |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame finished pulse |

## Verification
Random reads and writes cover every word size, many addresses and lengths, and partial source counts. The header check shows that the address bytes are not swapped. Asymmetric buffer contents show whether the reversal uses the correct word width, and short source counts show that the zero fill is applied at the right boundary. Directed cases cover the 240-byte maximum, the minimum 2-byte chunk and a start pulse issued mid-frame. The dummy-phase lengths are checked by counting the bits captured per frame and comparing the count with the frame type.

// File: rtl/spi_window_master.sv
module spi_window_master #(
  parameter int CLK_DIV = 2,
  parameter int MAX_LEN = 240,
  parameter int LW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd_mode,
  input  logic [1:0]    word_sel,
  input  logic [7:0]    opcode,
  input  logic [31:0]   addr,
  input  logic [LW-1:0] len,
  input  logic [LW-1:0] src_len,
  output logic [LW-1:0] wr_idx,
  input  logic [7:0]    wr_byte,
  output logic          rd_we,
  output logic [LW-1:0] rd_idx,
  output logic [7:0]    rd_byte,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          cs_n,
  output logic          busy,
  output logic          done
);
  localparam int FB = $clog2(MAX_LEN + 10);
  localparam int GW = $clog2(2 * CLK_DIV) + 1;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_t;
  st_t st;

  logic [GW-1:0] cnt;
  logic [2:0]    bitn;
  logic [FB-1:0] byten;
  logic [6:0]    sh;
  logic          r_rd;
  logic [1:0]    r_ws;
  logic [7:0]    r_op;
  logic [31:0]   r_addr;
  logic [LW-1:0] r_len, r_src;

  logic [FB-1:0] ds, dend, last;
  logic          in_data, tick;
  logic [LW-1:0] pos, mask, swz;
  logic [7:0]    tx_byte;

  assign ds      = r_rd ? FB'(9) : FB'(5);
  assign dend    = ds + FB'(r_len);
  assign last    = r_rd ? dend - FB'(1) : dend;
  assign in_data = (byten >= ds) && (byten < dend);
  assign pos     = LW'(byten - ds);
  assign mask    = (r_ws == 2'd0) ? LW'(1) : (r_ws == 2'd1) ? LW'(3) : LW'(7);
  assign swz     = pos ^ mask;
  assign wr_idx  = swz;
  assign tick    = cnt == GW'(CLK_DIV - 1);

  always_comb begin
    case (byten)
      FB'(0):  tx_byte = r_op;
      FB'(1):  tx_byte = r_addr[31:24];
      FB'(2):  tx_byte = r_addr[23:16];
      FB'(3):  tx_byte = r_addr[15:8];
      FB'(4):  tx_byte = r_addr[7:0];
      default: tx_byte = (!r_rd && in_data && swz < r_src) ? wr_byte : 8'h00;
    endcase
  end

  assign cs_n = st != S_XFER;
  assign busy = st != S_IDLE;
  assign mosi = cs_n ? 1'b0 : tx_byte[3'd7 - bitn];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      byten   <= '0;
      sh      <= '0;
      sclk    <= 1'b0;
      done    <= 1'b0;
      rd_we   <= 1'b0;
      rd_idx  <= '0;
      rd_byte <= '0;
      r_rd    <= 1'b0;
      r_ws    <= '0;
      r_op    <= '0;
      r_addr  <= '0;
      r_len   <= '0;
      r_src   <= '0;
    end else begin
      done  <= 1'b0;
      rd_we <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_XFER;
          cnt    <= '0;
          bitn   <= '0;
          byten  <= '0;
          sclk   <= 1'b0;
          r_rd   <= rd_mode;
          r_ws   <= word_sel;
          r_op   <= opcode;
          r_addr <= addr;
          r_len  <= len;
          r_src  <= src_len;
        end
        S_XFER: begin
          cnt <= tick ? '0 : cnt + GW'(1);
          if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
              sh   <= {sh[5:0], miso};
              if (bitn == 3'd7 && in_data && r_rd) begin
                rd_we   <= 1'b1;
                rd_idx  <= swz;
                rd_byte <= {sh, miso};
              end
            end else begin
              sclk <= 1'b0;
              bitn <= bitn + 3'd1;
              if (bitn == 3'd7) begin
                if (byten == last) begin
                  st  <= S_GAP;
                  cnt <= '0;
                end else begin
                  byten <= byten + FB'(1);
                end
              end
            end
          end
        end
        S_GAP: begin
          cnt <= cnt + GW'(1);
          if (cnt == GW'(2 * CLK_DIV - 1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_window_master_chk.sv
module spi_window_master_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic busy,
  input logic done,
  input logic rd_we
);
  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_cs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  assert_rdwe_inframe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> busy);
endmodule

bind spi_window_master spi_window_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
  .busy(busy), .done(done), .rd_we(rd_we)
);

// File: tb/tb_spi_window_master.sv
module tb_spi_window_master;
  localparam int CLK_DIV = 2;
  localparam int LW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_mode = 1'b0;
  logic [1:0] word_sel = '0;
  logic [7:0] opcode = '0;
  logic [31:0] addr = '0;
  logic [LW-1:0] len = '0, src_len = '0;
  logic [LW-1:0] wr_idx, rd_idx;
  logic [7:0] wr_byte, rd_byte;
  logic rd_we, sclk, mosi, miso, cs_n, busy, done;

  always #2 clk = ~clk;

  spi_window_master #(.CLK_DIV(CLK_DIV)) dut (.*);

  logic [7:0] wmem [0:255];
  logic [7:0] rmem [0:255];
  logic [7:0] resp [0:255];
  logic [7:0] cap  [0:255];
  logic [7:0] expf [0:255];
  int nbits = 0, gcnt = 0, ndone = 0;
  logic sclk_d = 1'b0;
  int checks = 0, fails = 0;

  assign wr_byte = wmem[wr_idx];
  assign miso = resp[(nbits / 8) % 256][7 - (nbits % 8)];

  always @(posedge clk) begin
    sclk_d <= sclk;
    if (start && !busy) begin
      nbits <= 0; gcnt <= 0; ndone <= 0;
    end else begin
      if (!cs_n && sclk && !sclk_d) begin
        cap[(nbits / 8) % 256][7 - (nbits % 8)] <= mosi;
        nbits <= nbits + 1;
      end
      if (cs_n && busy) gcnt <= gcnt + 1;
      if (done) ndone <= ndone + 1;
    end
    if (rd_we) rmem[rd_idx] <= rd_byte;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int wsz(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 4 : 8;
  endfunction

  task automatic frame(input bit rd, input logic [1:0] ws, input logic [7:0] op,
                       input logic [31:0] a, input int n, input int src, input bit poke);
    int nb, m, bad_i, bad_a, bad_e;
    bit ok;
    m = wsz(ws) - 1;
    for (int i = 0; i < 256; i++) begin
      wmem[i] = 8'($urandom);
      resp[i] = 8'($urandom);
      rmem[i] = 8'h5a;
      cap[i]  = 8'h00;
      expf[i] = 8'h00;
    end
    expf[0] = op; expf[1] = a[31:24]; expf[2] = a[23:16]; expf[3] = a[15:8]; expf[4] = a[7:0];
    if (!rd)
      for (int p = 0; p < n; p++) expf[5 + p] = ((p ^ m) < src) ? wmem[p ^ m] : 8'h00;
    nb = rd ? 9 + n : 6 + n;
    @(negedge clk);
    rd_mode = rd; word_sel = ws; opcode = op; addr = a;
    len = LW'(n); src_len = LW'(src); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (60) @(negedge clk);
      opcode = ~op; addr = ~a; rd_mode = ~rd; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(nbits == 8 * nb, rd ? "R3 read frame length" : "R4 write frame length", nbits, 8 * nb);
    ok = 1; bad_i = 0; bad_a = 0; bad_e = 0;
    for (int i = 0; i < 5; i++)
      if (ok && cap[i] != expf[i]) begin ok = 0; bad_i = i; bad_a = cap[i]; bad_e = expf[i]; end
    chk(ok, "R2 header bytes", bad_a, bad_e);
    ok = 1;
    for (int i = 5; i < nb; i++)
      if (ok && cap[i] != expf[i]) begin ok = 0; bad_i = i; bad_a = cap[i]; bad_e = expf[i]; end
    chk(ok, rd ? "R3 dummy/data mosi zero" : "R5 R6 write data order/zero fill", bad_a, bad_e);
    if (rd) begin
      ok = 1;
      for (int p = 0; p < n; p++)
        if (ok && rmem[p ^ m] != resp[9 + p]) begin ok = 0; bad_a = rmem[p ^ m]; bad_e = resp[9 + p]; end
      chk(ok, "R7 read data placement", bad_a, bad_e);
    end
    chk(gcnt == 2 * CLK_DIV, "R9 cs high gap before done", gcnt, 2 * CLK_DIV);
    chk(ndone == 1 && !busy && cs_n, "R10 single done, idle after", ndone, 1);
  endtask

  initial begin
    #(4 * 195000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !done && !rd_we, "R1 reset state",
        {cs_n, sclk, busy, done, rd_we}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !busy, "R1 idle after reset", {cs_n, busy}, 2'b10);
    frame(0, 2'd2, 8'h05, 32'h6003_0008, 240, 240, 0);   // R11 write max
    frame(1, 2'd2, 8'h04, 32'h6003_0008, 240, 0, 0);     // R11 read max
    frame(1, 2'd0, 8'h00, 32'h6003_0002, 2, 0, 0);       // minimum chunk
    frame(0, 2'd0, 8'h01, 32'h1234_5678, 2, 1, 0);       // R6 partial word
    frame(0, 2'd2, 8'h05, 32'h5000_0000, 16, 11, 0);     // R6 mid-word boundary
    frame(0, 2'd1, 8'h03, 32'hdead_beef, 8, 8, 1);       // R10 start while busy
    frame(1, 2'd1, 8'h02, 32'h0102_0304, 12, 0, 1);      // R10 start while busy
    for (int k = 0; k < 16; k++) begin
      logic [1:0] ws;
      int w, n, s;
      bit r;
      ws = 2'($urandom % 3);
      w = wsz(ws);
      n = w * (1 + int'($urandom % (48 / w)));
      s = int'($urandom % (n + 1));
      r = 1'($urandom);
      frame(r, ws, 8'($urandom), $urandom, n, s, 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule